// File: doc/BRIEF.md
# Capture-Compare Channel with Interlocked Event Flag

One channel of a timer. It runs either as an input capture or as an output compare against a free-running counter that sits outside the block. A single byte-wide status/control register on a simple CPU read/write strobe bus holds these fields: the event flag, the interrupt enable, two mode bits, two edge/action bits, a toggle-on-overflow bit and a max-duty bit. In capture mode, a selected edge on the channel pin, after synchronization, sets the flag and latches the counter. In compare mode, equality between the counter and the compare value sets the flag and drives the compare-output pin.

The flag is cleared by a handshake. Software must first read the register while the flag is 1, then write 0 to the flag bit. Any channel event that arrives after that read, or in the same cycle as the write, cancels the clear, so a pending request is never lost. The interrupt request is the flag gated by the enable.

Top module: `ccf_channel`

## Requirements
- R1: After reset the register reads 0x00, `irq` is 0 and `oc_pin` is 0.
- R2: Register bits 6..0 are interrupt enable (6), mode B (5), mode A (4), edge/action B (3), edge/action A (2), toggle-on-overflow (1) and max duty (0), and all of them read back as written. When parameter `MSB_EN` is 0, bit 5 always reads 0.
- R3: Capture mode is selected when mode B and mode A are both 0. The pin passes through two synchronizer flops. Edge code {B,A} = 01 means rising, 10 falling, 11 both, and 00 gives no event. A matching edge sets bit 7 on the third clock edge after the pin changes.
- R4: On a capture event, `cap_val` takes the `cnt_val` of the same cycle in which the flag is set.
- R5: Compare mode is selected when mode A or mode B is 1. In that mode, `cnt_val == cmp_val` sets the flag on the next clock edge.
- R6: A read that returns bit 7 = 1, followed by a write with bit 7 = 0, clears the flag.
- R7: A write of 0 to bit 7 with no qualifying read leaves the flag set. Any write consumes the qualification.
- R8: A channel event after the qualifying read, or in the same cycle as the write, leaves the flag set.
- R9: Writing 1 to bit 7 never sets or clears the flag.
- R10: `irq` is 1 exactly while the flag and the interrupt enable are both 1.
- R11: In compare mode, a match acts on the output pin according to the edge code: 01 toggles it, 10 clears it, 11 sets it, and 00 leaves it unchanged.
- R12: In compare mode with toggle-on-overflow = 1, a `cnt_ovf` pulse with no match toggles the output pin.
- R13: In compare mode with max duty = 1, `oc_pin` reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_rd | input | 1 | Register read strobe |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Register read data |
| cnt_val | input | CNT_W | Free-running counter value |
| cnt_ovf | input | 1 | Counter overflow pulse |
| cmp_val | input | CNT_W | Compare value |
| ch_pin | input | 1 | Channel input pin |
| irq | output | 1 | Interrupt request |
| cap_val | output | CNT_W | Captured counter value |
| oc_pin | output | 1 | Compare output pin |

## Verification
The assertions assume that `cpu_rd` and `cpu_wr` are never high in the same cycle, and that each strobe lasts one cycle per access. The bench only ever drives one strobe per cycle and releases it before the next access. The assertions also assume that `cnt_val` stays stable around capture windows when latch values are compared. The directed capture tests hold the counter constant while the pin edge passes through the synchronizer. The random phase varies matches, reads and writes cycle by cycle, and it keeps the configuration bits fixed so that the flag model depends only on the handshake.

// File: rtl/ccf_pkg.sv
package ccf_pkg;
  localparam int REG_W = 8;
  localparam int FLAG_BIT = 7;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  typedef struct packed {
    logic ie;
    logic msb;
    logic msa;
    logic elsb;
    logic elsa;
    logic tov;
    logic maxd;
  } ctl_t;
endpackage

// File: rtl/ccf_edge_det.sv
module ccf_edge_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pin,
  input  logic                en,
  input  ccf_pkg::edge_sel_e  sel,
  output logic                hit
);
  import ccf_pkg::*;
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh_q, sh_d;
  logic cur, prev;

  always_comb begin
    sh_d = {sh_q[SH_W-2:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign cur  = sh_q[SYNC_STAGES-1];
  assign prev = sh_q[SYNC_STAGES];

  always_comb begin
    hit = 1'b0;
    if (en) begin
      unique case (sel)
        EDGE_RISE: hit = cur & ~prev;
        EDGE_FALL: hit = ~cur & prev;
        EDGE_BOTH: hit = cur ^ prev;
        default:   hit = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/ccf_flag_ctl.sv
module ccf_flag_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ev,
  input  logic rd,
  input  logic wr,
  input  logic wr_flag,
  output logic flag,
  output logic arm
);
  logic flag_q, flag_d, arm_q, arm_d;

  always_comb begin
    arm_d = arm_q;
    if (ev)      arm_d = 1'b0;
    else if (wr) arm_d = 1'b0;
    else if (rd) arm_d = flag_q;
  end

  always_comb begin
    flag_d = flag_q;
    if (ev)                            flag_d = 1'b1;
    else if (wr && !wr_flag && arm_q)  flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag = flag_q;
  assign arm  = arm_q;
endmodule

// File: rtl/ccf_oc_out.sv
module ccf_oc_out (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               oc_en,
  input  logic               match,
  input  logic               ovf,
  input  ccf_pkg::edge_sel_e act,
  input  logic               tov,
  input  logic               maxd,
  output logic               pin_out
);
  import ccf_pkg::*;
  logic pin_q, pin_d, pin_en;

  always_comb begin
    pin_d  = pin_q;
    pin_en = 1'b0;
    if (oc_en && match) begin
      pin_en = 1'b1;
      unique case (act)
        EDGE_RISE: pin_d = ~pin_q;
        EDGE_FALL: pin_d = 1'b0;
        EDGE_BOTH: pin_d = 1'b1;
        default:   pin_d = pin_q;
      endcase
    end else if (oc_en && tov && ovf) begin
      pin_en = 1'b1;
      pin_d  = ~pin_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pin_q <= 1'b0;
    else if (pin_en) pin_q <= pin_d;
  end

  assign pin_out = (oc_en && maxd) ? 1'b1 : pin_q;
endmodule

// File: rtl/ccf_channel.sv
module ccf_channel #(
  parameter int CNT_W  = 16,
  parameter bit MSB_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_rd,
  input  logic             cpu_wr,
  input  logic [7:0]       cpu_wdata,
  output logic [7:0]       cpu_rdata,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_ovf,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             ch_pin,
  output logic             irq,
  output logic [CNT_W-1:0] cap_val,
  output logic             oc_pin
);
  import ccf_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_sn;
  ctl_t       ctl_q, ctl_d;
  logic [CNT_W-1:0] cap_q;
  logic       oc_mode, cmp_hit, cap_hit, ch_event, cap_event;
  logic       flag_q, clr_arm;
  edge_sel_e  sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  always_comb begin
    ctl_d = ctl_q;
    if (cpu_wr) begin
      ctl_d = ctl_t'(cpu_wdata[FLAG_BIT-1:0]);
      if (!MSB_EN) ctl_d.msb = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) ctl_q <= '0;
    else         ctl_q <= ctl_d;
  end

  assign oc_mode = ctl_q.msb | ctl_q.msa;
  assign sel     = edge_sel_e'({ctl_q.elsb, ctl_q.elsa});
  assign cmp_hit = (cnt_val == cmp_val);

  ccf_edge_det #(.SYNC_STAGES(2)) u_edge (
    .clk(clk), .rst_n(rst_sn), .pin(ch_pin), .en(!oc_mode), .sel(sel),
    .hit(cap_hit)
  );

  assign cap_event = cap_hit & ~oc_mode;
  assign ch_event  = cap_event | (cmp_hit & oc_mode);

  ccf_flag_ctl u_flag (
    .clk(clk), .rst_n(rst_sn), .ev(ch_event), .rd(cpu_rd), .wr(cpu_wr),
    .wr_flag(cpu_wdata[FLAG_BIT]), .flag(flag_q), .arm(clr_arm)
  );

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)        cap_q <= '0;
    else if (cap_event) cap_q <= cnt_val;
  end

  ccf_oc_out u_oc (
    .clk(clk), .rst_n(rst_sn), .oc_en(oc_mode), .match(cmp_hit),
    .ovf(cnt_ovf), .act(sel), .tov(ctl_q.tov), .maxd(ctl_q.maxd),
    .pin_out(oc_pin)
  );

  assign cpu_rdata = {flag_q, ctl_q};
  assign irq       = flag_q & ctl_q.ie;
  assign cap_val   = cap_q;
endmodule

// File: rtl/ccf_channel_chk.sv
module ccf_channel_chk #(
  parameter int CNT_W  = 16,
  parameter bit MSB_EN = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_wr,
  input logic [7:0]       cpu_wdata,
  input logic [7:0]       cpu_rdata,
  input logic             ev,
  input logic             cap_ev,
  input logic             arm,
  input logic             irq,
  input logic [CNT_W-1:0] cnt_val,
  input logic [CNT_W-1:0] cap_val
);
  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ev |=> cpu_rdata[7]); // R8
  AST_ONLY_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rdata[7]) |-> $past(ev)); // R9
  AST_ARMED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_rdata[7]) |-> $past(arm && cpu_wr && !cpu_wdata[7])); // R7
  AST_CAP_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |=> (cap_val == $past(cnt_val))); // R4
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (cpu_rdata[7] && cpu_rdata[6])); // R10
  generate
    if (!MSB_EN) begin : g_nomsb
      AST_MSB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rdata[5]); // R2
    end
  endgenerate
endmodule

bind ccf_channel ccf_channel_chk #(.CNT_W(CNT_W), .MSB_EN(MSB_EN)) u_chk (
  .clk(clk), .rst_n(rst_sn), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
  .cpu_rdata(cpu_rdata), .ev(ch_event), .cap_ev(cap_event), .arm(clr_arm),
  .irq(irq), .cnt_val(cnt_val), .cap_val(cap_val)
);

// File: tb/ccf_channel_test.sv
module ccf_channel_test;
  localparam int CLK_PER = 10;
  localparam int CNT_W = 16;
  localparam int WDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] rdata, rdata2;
  logic [CNT_W-1:0] cnt_val = '0, cmp_val = 16'hFFFF;
  logic cnt_ovf = 1'b0, ch_pin = 1'b0;
  logic irq, irq2, oc_pin, oc_pin2;
  logic [CNT_W-1:0] cap_val, cap_val2;

  int checks = 0, fails = 0, cyc = 0;
  logic mflag, marm;
  logic [7:0] rv;

  always #(CLK_PER/2) clk = ~clk;

  ccf_channel #(.CNT_W(CNT_W), .MSB_EN(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(rdata), .cnt_val(cnt_val),
    .cnt_ovf(cnt_ovf), .cmp_val(cmp_val), .ch_pin(ch_pin), .irq(irq),
    .cap_val(cap_val), .oc_pin(oc_pin));

  ccf_channel #(.CNT_W(CNT_W), .MSB_EN(1'b0)) uut2 (
    .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(rdata2), .cnt_val(cnt_val),
    .cnt_ovf(cnt_ovf), .cmp_val(cmp_val), .ch_pin(ch_pin), .irq(irq2),
    .cap_val(cap_val2), .oc_pin(oc_pin2));

  function automatic logic exp_irq(input logic f, input logic ie);
    return f & ie;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); cpu_wr = 1'b1; cpu_wdata = d;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic rd(output logic [7:0] d);
    @(negedge clk); cpu_rd = 1'b1; d = rdata;
    @(negedge clk); cpu_rd = 1'b0;
  endtask

  task automatic match_pulse();
    @(negedge clk); cnt_val = cmp_val;
    @(negedge clk); cnt_val = 16'h0000;
  endtask

  task automatic ovf_pulse();
    @(negedge clk); cnt_ovf = 1'b1;
    @(negedge clk); cnt_ovf = 1'b0;
  endtask

  task automatic pin_set(input logic v);
    @(negedge clk); ch_pin = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic clear_flag(input logic [7:0] cfg);
    rd(rv); wr(cfg);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(rdata == 8'h00 && !irq && !oc_pin, "R1 reset", rdata, 0);

    wr(8'h7F);
    @(negedge clk);
    chk(rdata == 8'h7F, "R2 readback", rdata, 8'h7F);
    chk(rdata2 == 8'h5F, "R2 mode B absent", rdata2, 8'h5F);
    wr(8'h2A);
    chk(rdata == 8'h2A, "R2 readback2", rdata, 8'h2A);
    chk(rdata2 == 8'h0A, "R2 mode B absent2", rdata2, 8'h0A);

    // capture rising
    wr(8'h04);
    cnt_val = 16'h1234;
    pin_set(1'b1);
    chk(rdata[7] == 1'b1, "R3 rising edge", rdata[7], 1);
    chk(cap_val == 16'h1234, "R4 capture latch", cap_val, 16'h1234);
    clear_flag(8'h04);
    chk(rdata[7] == 1'b0, "R6 clear", rdata[7], 0);
    pin_set(1'b0);
    chk(rdata[7] == 1'b0, "R3 falling ignored in rising mode", rdata[7], 0);
    wr(8'h08);
    cnt_val = 16'h0BEE;
    pin_set(1'b1);
    chk(rdata[7] == 1'b0, "R3 rising ignored in falling mode", rdata[7], 0);
    pin_set(1'b0);
    chk(rdata[7] == 1'b1, "R3 falling edge", rdata[7], 1);
    chk(cap_val == 16'h0BEE, "R4 capture latch falling", cap_val, 16'h0BEE);
    clear_flag(8'h00);
    pin_set(1'b1);
    pin_set(1'b0);
    chk(rdata[7] == 1'b0, "R3 edge code 00 no event", rdata[7], 0);
    wr(8'h0C);
    pin_set(1'b1);
    chk(rdata[7] == 1'b1, "R3 both edges rise", rdata[7], 1);
    clear_flag(8'h0C);
    pin_set(1'b0);
    chk(rdata[7] == 1'b1, "R3 both edges fall", rdata[7], 1);

    // handshake corners
    wr(8'h0C);
    chk(rdata[7] == 1'b1, "R7 write 0 without read", rdata[7], 1);
    rd(rv);
    wr(8'h8C);
    chk(rdata[7] == 1'b1, "R9 write 1 keeps flag", rdata[7], 1);
    wr(8'h0C);
    chk(rdata[7] == 1'b1, "R7 qualification consumed", rdata[7], 1);
    wr(8'h4C);
    chk(irq == exp_irq(1'b1, 1'b1), "R10 irq on", irq, 1);
    clear_flag(8'h4C);
    chk(rdata[7] == 1'b0 && irq == 1'b0, "R6 clear with enable", rdata, 8'h4C);
    wr(8'h8C);
    chk(rdata[7] == 1'b0, "R9 write 1 no set", rdata[7], 0);

    // event between read and write, compare mode
    cnt_val = 16'h0000; cmp_val = 16'h0005;
    wr(8'h50);
    match_pulse();
    chk(rdata[7] == 1'b1, "R5 compare match", rdata[7], 1);
    rd(rv);
    match_pulse();
    wr(8'h50);
    chk(rdata[7] == 1'b1, "R8 event cancels clear", rdata[7], 1);
    rd(rv);
    @(negedge clk); cpu_wr = 1'b1; cpu_wdata = 8'h50; cnt_val = cmp_val;
    @(negedge clk); cpu_wr = 1'b0; cnt_val = 16'h0000;
    chk(rdata[7] == 1'b1, "R8 event same cycle as write", rdata[7], 1);
    wr(8'h10);
    chk(irq == 1'b0, "R10 irq off when disabled", irq, 0);
    clear_flag(8'h10);

    // output compare pin
    wr(8'h14);
    match_pulse();
    chk(oc_pin == 1'b1, "R11 toggle", oc_pin, 1);
    match_pulse();
    chk(oc_pin == 1'b0, "R11 toggle back", oc_pin, 0);
    wr(8'h1C);
    match_pulse();
    chk(oc_pin == 1'b1, "R11 set", oc_pin, 1);
    wr(8'h18);
    match_pulse();
    chk(oc_pin == 1'b0, "R11 clear", oc_pin, 0);
    wr(8'h10);
    match_pulse();
    chk(oc_pin == 1'b0, "R11 code 00 unchanged", oc_pin, 0);
    wr(8'h12);
    ovf_pulse();
    chk(oc_pin == 1'b1, "R12 overflow toggle", oc_pin, 1);
    ovf_pulse();
    chk(oc_pin == 1'b0, "R12 overflow toggle back", oc_pin, 0);
    wr(8'h11);
    chk(oc_pin == 1'b1, "R13 max duty", oc_pin, 1);
    wr(8'h10);
    chk(oc_pin == 1'b0, "R13 max duty off", oc_pin, 0);

    // random handshake traffic, compare mode, IE on
    wr(8'hD0);
    mflag = rdata[7];
    marm = 1'b0;
    for (int i = 0; i < 400; i++) begin
      int r;
      logic ev, rq, wq, wb;
      r = $urandom % 8;
      ev = (r < 2);
      rq = (r >= 2 && r <= 4);
      wq = (r >= 5);
      wb = $urandom % 2;
      cpu_rd = rq; cpu_wr = wq; cpu_wdata = {wb, 7'h50};
      cnt_val = ev ? cmp_val : 16'h0000;
      @(negedge clk);
      if (ev) begin
        mflag = 1'b1; marm = 1'b0;
      end else if (wq) begin
        if (!wb && marm) mflag = 1'b0;
        marm = 1'b0;
      end else if (rq) begin
        marm = mflag;
      end
      chk(rdata[7] == mflag, "R6 R7 R8 random flag", rdata[7], mflag);
      chk(irq == exp_irq(mflag, 1'b1), "R10 random irq", irq, mflag);
    end
    cpu_rd = 1'b0; cpu_wr = 1'b0; cnt_val = 16'h0000;
    @(negedge clk);
    finish_run();
  end
endmodule